// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block lets an I2C bus master read and write a bank of five byte-wide configuration registers. The bus lines come in raw. Each line is resynchronised into the system clock domain, and edges are found on the resynchronised samples. The block answers one 7-bit bus address: a fixed `0101` upper nibble followed by three strap inputs. A register pointer is loaded by an address byte. Reads move the pointer forward by one after each byte.

A write carries one data byte. The byte is held back and reaches the register bank only when a STOP condition ends the transfer cleanly. At that moment the block emits a one-cycle commit request with the address and data, so that a nonvolatile storage controller can start its own write cycle. While that controller reports busy (a storage write or a power-up recall), the block leaves the bus alone and releases SDA.

Register 0 drives a reference code and register 1 drives a slope code. The two low bits of register 2 are decoded into an output-gain selector.

Top module: `i2c_cfg_regs`

## Requirements
- R1: The slave acknowledges an identification byte only if its upper seven bits equal `0101` followed by `strap[2:0]` (bit 0 = R/W, 1 = read). On a mismatch it gives no ACK to that byte or to any later byte until the next START, and no register changes.
- R2: A write of START, ID with R/W=0, address byte, one data byte and STOP is acknowledged on each of its three bytes (SDA held low through the ninth SCL high phase). At the STOP, the register at that address takes the data byte, and `commit_req` pulses for one cycle carrying `commit_addr` and `commit_data`.
- R3: A received data byte changes no register and raises no commit before the STOP arrives. A STOP that arrives in the middle of a data byte discards the write.
- R4: Within one write transfer, a second data byte is not acknowledged. The value committed at STOP is the first data byte.
- R5: A random read (START, ID write, address byte, repeated START, ID read) returns the register at that address, MSB first. Further bytes follow at successive addresses for as long as the master ACKs. After a master NACK the slave releases SDA.
- R6: A current-address read starts at the pointer left by the previous transfer. After a write, that pointer is the written address. After a read, it is one past the last byte sent. It wraps from 0xFF to 0x00.
- R7: Reading a pointer value of 5 or above returns 0xFF. A write to such an address is acknowledged but changes nothing and raises no commit.
- R8: While `nv_busy` is high, SDA is released on the next clock and the slave gives no ACK. A transfer that was under way is dropped, along with any data it held.
- R9: The two low bits of register 2 decode to `gain_sel`: 00 gives 0 (x1), 01 and 10 both give 1 (x2), and 11 gives 2 (x4). The value 3 never appears.
- R10: The slave changes SDA only while the synchronised SCL is low. Its ACK level holds steady through the whole SCL high phase.
- R11: After reset, all registers are zero, `gain_sel` is 0, SDA is released, no commit is pending and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad (wired bus value) |
| strap | input | 3 | Pin-strapped low address bits |
| nv_busy | input | 1 | Storage write or recall in progress; bus is ignored |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| commit_req | output | 1 | One-cycle request to store a register write |
| commit_addr | output | ADDR_W | Register index of the commit |
| commit_data | output | 8 | Data byte of the commit |
| ref_code | output | 8 | Contents of register 0 |
| slope_code | output | 8 | Contents of register 1 |
| gain_sel | output | 2 | Decoded gain: 0 = x1, 1 = x2, 2 = x4 |

## Verification
The bench uses the defaults: five registers, two synchroniser stages and a 0xFF fill byte. With only five valid addresses out of 256 pointer values, a short run of auto-incrementing reads already passes the end of the bank. A read starting at 0xFF shows both the fill value and the wrap back to register 0. Because SCL is held well above the synchroniser latency, every ACK edge can be seen settling inside the SCL low phase, and each abort point (mid-byte STOP, NACKed second byte, busy raised mid-transfer) can be placed on an exact bit.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 4;
  localparam int PFX_W   = 4;
  localparam int STRAP_W = BYTE_W - 1 - PFX_W;
  localparam logic [PFX_W-1:0] ID_PREFIX = 4'b0101;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_REG,
    PH_WR,
    PH_RD,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    GAIN_X1 = 2'd0,
    GAIN_X2 = 2'd1,
    GAIN_X4 = 2'd2
  } gain_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_raw};
      sda_ff <= {sda_ff[STAGES-2:0], sda_raw};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign bus_start = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank import i2c_cfg_pkg::*; #(
  parameter int               NUM_REGS  = 5,
  parameter int               ADDR_W    = 3,
  parameter logic [BYTE_W-1:0] FILL_BYTE = 8'hFF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] ptr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] ref_code,
  output logic [BYTE_W-1:0] slope_code,
  output logic [1:0]        gain_sel
);
  logic [NUM_REGS-1:0][BYTE_W-1:0] reg_flat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              hit;
    logic [BYTE_W-1:0] q;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign reg_flat[g] = q;
  end

  always_comb begin
    rd_data = FILL_BYTE;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr == BYTE_W'(i)) rd_data = reg_flat[i];
    end
  end

  assign ref_code   = reg_flat[0];
  assign slope_code = reg_flat[1];

  gain_t gain_dec;
  always_comb begin
    case (reg_flat[2][1:0])
      2'b00:   gain_dec = GAIN_X1;
      2'b11:   gain_dec = GAIN_X4;
      default: gain_dec = GAIN_X2;
    endcase
  end
  assign gain_sel = gain_dec;
endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine import i2c_cfg_pkg::*; #(
  parameter int NUM_REGS = 5,
  parameter int ADDR_W   = 3
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_lvl,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               bus_start,
  input  logic               bus_stop,
  input  logic               busy,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic [BYTE_W-1:0]  ptr,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               sda_pull
);
  phase_t             ph_q, ph_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [BYTE_W-1:0]  sh_q, sh_n;
  logic [BYTE_W-1:0]  tx_q, tx_n;
  logic [BYTE_W-1:0]  ptr_q, ptr_n;
  logic               pend_v_q, pend_v_n;
  logic [BYTE_W-1:0]  pend_d_q, pend_d_n;
  logic [BYTE_W-1:0]  pend_a_q, pend_a_n;
  logic               rd_dir_q, rd_dir_n;
  logic               mack_q, mack_n;
  logic               pull_q, pull_n;
  logic               wr_en_q, wr_en_n;
  logic [ADDR_W-1:0]  wr_a_q, wr_a_n;
  logic [BYTE_W-1:0]  wr_d_q, wr_d_n;
  logic               id_match;
  logic               active;

  assign id_match = (sh_q[BYTE_W-1:1] == {ID_PREFIX, strap});
  assign active   = (ph_q != PH_IDLE) && (ph_q != PH_SKIP);

  always_comb begin
    ph_n     = ph_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    tx_n     = tx_q;
    ptr_n    = ptr_q;
    pend_v_n = pend_v_q;
    pend_d_n = pend_d_q;
    pend_a_n = pend_a_q;
    rd_dir_n = rd_dir_q;
    mack_n   = mack_q;
    pull_n   = pull_q;
    wr_en_n  = 1'b0;
    wr_a_n   = wr_a_q;
    wr_d_n   = wr_d_q;

    if (busy) begin
      ph_n     = PH_IDLE;
      cnt_n    = '0;
      pull_n   = 1'b0;
      pend_v_n = 1'b0;
    end else if (bus_start) begin
      ph_n     = PH_DEV;
      cnt_n    = '0;
      pull_n   = 1'b0;
      pend_v_n = 1'b0;
    end else if (bus_stop) begin
      if (pend_v_q && (int'(pend_a_q) < NUM_REGS)) begin
        wr_en_n = 1'b1;
        wr_a_n  = pend_a_q[ADDR_W-1:0];
        wr_d_n  = pend_d_q;
      end
      ph_n     = PH_IDLE;
      cnt_n    = '0;
      pull_n   = 1'b0;
      pend_v_n = 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (cnt_q < CNT_W'(8)) sh_n = {sh_q[BYTE_W-2:0], sda_lvl};
        if (cnt_q == CNT_W'(8) && ph_q == PH_RD) mack_n = ~sda_lvl;
        cnt_n = cnt_q + CNT_W'(1);
      end else if (scl_fall) begin
        if (cnt_q == CNT_W'(8)) begin
          pull_n = 1'b0;
          case (ph_q)
            PH_DEV: begin
              if (id_match) begin
                pull_n   = 1'b1;
                rd_dir_n = sh_q[0];
              end else begin
                ph_n = PH_SKIP;
              end
            end
            PH_REG: begin
              pull_n = 1'b1;
              ptr_n  = sh_q;
            end
            PH_WR: begin
              if (!pend_v_q) begin
                pull_n   = 1'b1;
                pend_d_n = sh_q;
                pend_a_n = ptr_q;
              end else begin
                ph_n = PH_SKIP;
              end
            end
            PH_RD:   ptr_n = ptr_q + BYTE_W'(1);
            default: ;
          endcase
        end else if (cnt_q == CNT_W'(9)) begin
          cnt_n  = '0;
          pull_n = 1'b0;
          case (ph_q)
            PH_DEV: begin
              if (rd_dir_q) begin
                ph_n   = PH_RD;
                tx_n   = rd_data;
                pull_n = ~rd_data[BYTE_W-1];
              end else begin
                ph_n = PH_REG;
              end
            end
            PH_REG: ph_n = PH_WR;
            PH_WR:  pend_v_n = 1'b1;
            PH_RD: begin
              if (mack_q) begin
                tx_n   = rd_data;
                pull_n = ~rd_data[BYTE_W-1];
              end else begin
                ph_n = PH_SKIP;
              end
            end
            default: ;
          endcase
        end else if (ph_q == PH_RD && cnt_q != '0) begin
          tx_n   = {tx_q[BYTE_W-2:0], 1'b0};
          pull_n = ~tx_q[BYTE_W-2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      pend_v_q <= 1'b0;
      pend_d_q <= '0;
      pend_a_q <= '0;
      rd_dir_q <= 1'b0;
      mack_q   <= 1'b0;
      pull_q   <= 1'b0;
      wr_en_q  <= 1'b0;
      wr_a_q   <= '0;
      wr_d_q   <= '0;
    end else begin
      ph_q     <= ph_n;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      tx_q     <= tx_n;
      ptr_q    <= ptr_n;
      pend_v_q <= pend_v_n;
      pend_d_q <= pend_d_n;
      pend_a_q <= pend_a_n;
      rd_dir_q <= rd_dir_n;
      mack_q   <= mack_n;
      pull_q   <= pull_n;
      wr_en_q  <= wr_en_n;
      wr_a_q   <= wr_a_n;
      wr_d_q   <= wr_d_n;
    end
  end

  assign ptr      = ptr_q;
  assign wr_en    = wr_en_q;
  assign wr_addr  = wr_a_q;
  assign wr_data  = wr_d_q;
  assign sda_pull = pull_q;
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs import i2c_cfg_pkg::*; #(
  parameter int                NUM_REGS    = 5,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] FILL_BYTE   = 8'hFF,
  localparam int               ADDR_W      = $clog2(NUM_REGS)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] strap,
  input  logic               nv_busy,
  output logic               sda_pull,
  output logic               commit_req,
  output logic [ADDR_W-1:0]  commit_addr,
  output logic [BYTE_W-1:0]  commit_data,
  output logic [BYTE_W-1:0]  ref_code,
  output logic [BYTE_W-1:0]  slope_code,
  output logic [1:0]         gain_sel
);
  logic [1:0]        rst_ff;
  logic              rst_int_n;
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic [BYTE_W-1:0] ptr, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_int_n = rst_ff[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_cfg_engine #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst_n(rst_int_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .busy(nv_busy), .strap(strap), .rd_data(rd_data), .ptr(ptr),
    .wr_en(commit_req), .wr_addr(commit_addr), .wr_data(commit_data),
    .sda_pull(sda_pull)
  );

  i2c_cfg_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .FILL_BYTE(FILL_BYTE)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .wr_en(commit_req), .wr_addr(commit_addr),
    .wr_data(commit_data), .ptr(ptr), .rd_data(rd_data),
    .ref_code(ref_code), .slope_code(slope_code), .gain_sel(gain_sel)
  );
endmodule

// File: rtl/i2c_cfg_regs_chk.sv
module i2c_cfg_regs_chk #(
  parameter int NUM_REGS = 5,
  parameter int ADDR_W   = 3
)(
  input logic              clk,
  input logic              rst_n,
  input logic              nv_busy,
  input logic              scl_sync,
  input logic              sda_pull,
  input logic              commit_req,
  input logic [ADDR_W-1:0] commit_addr,
  input logic [7:0]        ref_code,
  input logic [7:0]        slope_code,
  input logic [1:0]        gain_sel
);
  p_busy_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> !sda_pull);

  p_commit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |=> !commit_req);

  p_commit_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> (int'(commit_addr) < NUM_REGS));

  p_ref_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_code) |-> ($past(commit_req) && $past(commit_addr) == ADDR_W'(0)));

  p_slope_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slope_code) |-> ($past(commit_req) && $past(commit_addr) == ADDR_W'(1)));

  p_gain_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gain_sel != 2'd3);

  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && !$past(nv_busy)) |-> !scl_sync);
endmodule

bind i2c_cfg_regs i2c_cfg_regs_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nv_busy(nv_busy), .scl_sync(scl_lvl),
  .sda_pull(sda_pull), .commit_req(commit_req), .commit_addr(commit_addr),
  .ref_code(ref_code), .slope_code(slope_code), .gain_sel(gain_sel)
);

// File: tb/tb_i2c_cfg_regs.sv
module tb_i2c_cfg_regs;
  localparam int HALF = 16;
  localparam int NREG = 5;

  logic       clk = 1'b0;
  logic       rst_n, m_scl, m_sda, busy;
  logic [2:0] strap;
  logic       sda_pull, commit_req;
  logic [2:0] commit_addr;
  logic [7:0] commit_data, ref_code, slope_code;
  logic [1:0] gain_sel;
  wire        bus_sda = m_sda & ~sda_pull;

  int errors = 0;
  int checks = 0;
  int ccount = 0;
  bit done = 0;
  logic [2:0] last_ca;
  logic [7:0] last_cd;
  logic [7:0] mreg [NREG];
  logic [7:0] mptr;

  always #10 clk = ~clk;

  i2c_cfg_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(bus_sda), .strap(strap),
    .nv_busy(busy), .sda_pull(sda_pull), .commit_req(commit_req),
    .commit_addr(commit_addr), .commit_data(commit_data), .ref_code(ref_code),
    .slope_code(slope_code), .gain_sel(gain_sel)
  );

  always @(negedge clk) begin
    if (rst_n && commit_req) begin
      ccount  <= ccount + 1;
      last_ca <= commit_addr;
      last_cd <= commit_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] exp_gain(input logic [7:0] r);
    case (r[1:0])
      2'b00:   return 2'd0;
      2'b11:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    return (p < 8'd5) ? mreg[p[2:0]] : 8'hFF;
  endfunction

  function automatic logic [7:0] idw();
    return {4'b0101, strap, 1'b0};
  endfunction

  function automatic logic [7:0] idr();
    return {4'b0101, strap, 1'b1};
  endfunction

  task automatic bstart();
    m_sda = 1'b1; wclk(HALF);
    m_scl = 1'b1; wclk(HALF);
    m_sda = 1'b0; wclk(HALF);
    m_scl = 1'b0; wclk(HALF);
  endtask

  task automatic bstop();
    m_sda = 1'b0; wclk(HALF);
    m_scl = 1'b1; wclk(HALF);
    m_sda = 1'b1; wclk(HALF);
  endtask

  task automatic sbits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wclk(HALF);
      m_scl = 1'b1; wclk(HALF);
      m_scl = 1'b0; wclk(4);
    end
  endtask

  task automatic sbyte(input logic [7:0] b, output bit acked);
    bit a1, a2;
    sbits(b, 8);
    m_sda = 1'b1; wclk(HALF);
    m_scl = 1'b1; wclk(2);
    a1 = ~bus_sda; wclk(HALF - 2);
    a2 = ~bus_sda;
    m_scl = 1'b0; wclk(4);
    chk(a1 == a2, "R10 ack level steady while SCL high", {31'd0, a2}, {31'd0, a1});
    acked = a1;
  endtask

  task automatic rbyte(input bit ack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wclk(HALF);
      m_scl = 1'b1; wclk(HALF / 2);
      b = {b[6:0], bus_sda}; wclk(HALF / 2);
      m_scl = 1'b0; wclk(4);
    end
    m_sda = ~ack; wclk(HALF);
    m_scl = 1'b1; wclk(HALF);
    m_scl = 1'b0; wclk(4);
    m_sda = 1'b1;
  endtask

  task automatic outs(input string tag);
    chk(ref_code == mreg[0], {tag, " ref_code"}, ref_code, mreg[0]);
    chk(slope_code == mreg[1], {tag, " slope_code"}, slope_code, mreg[1]);
    chk(gain_sel == exp_gain(mreg[2]), {tag, " gain_sel"}, gain_sel, exp_gain(mreg[2]));
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string tag);
    bit k0, k1, k2;
    int c0;
    c0 = ccount;
    bstart(); sbyte(idw(), k0); sbyte(a, k1); sbyte(d, k2); bstop(); wclk(10);
    chk(k0 && k1 && k2, "R2 write acks", {k0, k1, k2}, 3'b111);
    mptr = a;
    if (a < 8'd5) begin
      mreg[a[2:0]] = d;
      chk(ccount == c0 + 1, "R2 commit count", ccount - c0, 1);
      chk(last_ca == a[2:0] && last_cd == d, "R2 commit payload", {last_ca, last_cd}, {a[2:0], d});
    end else begin
      chk(ccount == c0, "R7 no commit above range", ccount - c0, 0);
    end
    outs(tag);
  endtask

  task automatic do_read(input bit rnd, input logic [7:0] a, input int n, input string tag);
    bit k0, k1, k2;
    logic [7:0] b, e;
    if (rnd) begin
      bstart(); sbyte(idw(), k0); sbyte(a, k1);
      chk(k0 && k1, "R5 dummy write acks", {k0, k1}, 2'b11);
      mptr = a;
    end
    bstart(); sbyte(idr(), k2);
    chk(k2, "R5 read id ack", {31'd0, k2}, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, b);
      e = exp_rd(mptr);
      chk(b == e, (mptr >= 8'd5) ? "R7 fill byte" : tag, b, e);
      mptr = mptr + 8'd1;
    end
    wclk(4);
    chk(sda_pull == 1'b0, "R5 released after NACK", {31'd0, sda_pull}, 0);
    bstop(); wclk(10);
  endtask

  initial begin
    bit k0, k1, k2, k3;
    int c0;
    logic [7:0] g;
    void'($urandom(32'd2024));
    m_scl = 1'b1; m_sda = 1'b1; busy = 1'b0; strap = 3'b101;
    for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
    mptr = 8'h00;
    rst_n = 1'b0; wclk(5); rst_n = 1'b1; wclk(10);

    chk(sda_pull == 1'b0, "R11 sda released", {31'd0, sda_pull}, 0);
    chk(ccount == 0, "R11 no commit", ccount, 0);
    outs("R11 reset");
    do_read(1'b0, 8'h00, 1, "R11 pointer at zero");

    do_write(8'h00, 8'h5A, "R2 reg0");
    do_write(8'h01, 8'hC4, "R2 reg1");
    do_write(8'h04, 8'h9E, "R2 reg4");

    do_write(8'h02, 8'h00, "R9 gain 00");
    do_write(8'h02, 8'h01, "R9 gain 01");
    do_write(8'h02, 8'h02, "R9 gain 10");
    do_write(8'h02, 8'h03, "R9 gain 11");
    do_write(8'h02, 8'hFE, "R9 gain upper bits");

    do_read(1'b1, 8'h00, 3, "R5 random read");
    do_read(1'b0, 8'h00, 2, "R6 current read continues");
    do_write(8'h03, 8'h6B, "R6 write sets pointer");
    do_read(1'b0, 8'h00, 1, "R6 current read after write");

    do_read(1'b1, 8'h04, 3, "R7 read across end");
    do_write(8'h06, 8'h77, "R7 write above range");
    do_read(1'b1, 8'hFF, 2, "R6 pointer wrap");

    // R1: wrong strap bits and wrong prefix are ignored
    c0 = ccount;
    bstart(); sbyte({4'b0101, 3'b100, 1'b0}, k0); sbyte(8'h00, k1); sbyte(8'h11, k2); bstop(); wclk(10);
    chk(!k0 && !k1 && !k2, "R1 no ack on strap mismatch", {k0, k1, k2}, 0);
    bstart(); sbyte({4'b0111, strap, 1'b0}, k0); sbyte(8'h00, k1); bstop(); wclk(10);
    chk(!k0 && !k1, "R1 no ack on prefix mismatch", {k0, k1}, 0);
    chk(ccount == c0, "R1 no commit", ccount - c0, 0);
    outs("R1 unchanged");
    strap = 3'b010; wclk(5);
    do_write(8'h00, 8'h33, "R1 new strap accepted");
    strap = 3'b101; wclk(5);

    // R3: stop mid data byte
    c0 = ccount;
    bstart(); sbyte(idw(), k0); sbyte(8'h01, k1); sbits(8'hA5, 4); bstop(); wclk(10);
    mptr = 8'h01;
    chk(ccount == c0, "R3 mid-byte stop no commit", ccount - c0, 0);
    outs("R3 mid-byte stop");
    // R3: full data byte held until STOP
    bstart(); sbyte(idw(), k0); sbyte(8'h01, k1); sbyte(8'h3C, k2); wclk(30);
    chk(slope_code == mreg[1], "R3 no update before stop", slope_code, mreg[1]);
    chk(ccount == c0, "R3 no commit before stop", ccount - c0, 0);
    bstop(); wclk(10);
    mreg[1] = 8'h3C;
    chk(ccount == c0 + 1, "R3 commit at stop", ccount - c0, 1);
    outs("R3 after stop");

    // R4: second data byte refused
    c0 = ccount;
    bstart(); sbyte(idw(), k0); sbyte(8'h03, k1); sbyte(8'h11, k2); sbyte(8'h22, k3); bstop(); wclk(10);
    chk(k2 && !k3, "R4 second byte nacked", {k2, k3}, 2'b10);
    chk(ccount == c0 + 1 && last_cd == 8'h11, "R4 first byte committed", last_cd, 8'h11);
    mreg[3] = 8'h11; mptr = 8'h03;
    do_read(1'b0, 8'h00, 1, "R4 stored value");

    // R8: busy blocks the bus
    c0 = ccount;
    busy = 1'b1; wclk(3);
    chk(sda_pull == 1'b0, "R8 released while busy", {31'd0, sda_pull}, 0);
    bstart(); sbyte(idw(), k0); sbyte(8'h00, k1); sbyte(8'hEE, k2); bstop(); wclk(10);
    chk(!k0 && !k1 && !k2, "R8 no ack while busy", {k0, k1, k2}, 0);
    busy = 1'b0; wclk(5);
    bstart(); sbyte(idw(), k0); sbyte(8'h00, k1);
    busy = 1'b1; wclk(3);
    sbyte(8'hC3, k2);
    busy = 1'b0; wclk(3);
    bstop(); wclk(10);
    mptr = 8'h00;
    chk(!k2, "R8 data refused after busy", {31'd0, k2}, 0);
    chk(ccount == c0, "R8 no commit", ccount - c0, 0);
    outs("R8 unchanged");
    do_read(1'b0, 8'h00, 1, "R8 pointer kept");

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      int op;
      logic [7:0] a;
      op = int'($urandom % 3);
      a  = 8'($urandom % 7);
      g  = 8'($urandom);
      case (op)
        0:       do_write(a, g, "R2 random write");
        1:       do_read(1'b1, a, 1 + int'($urandom % 3), "R5 random read");
        default: do_read(1'b0, 8'h00, 1 + int'($urandom % 2), "R6 random current read");
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule